// File: doc/BRIEF.md
# HDLC channel FIFO controller

This block is the host-facing register and FIFO front end of one framed data channel. A host talks to it through a single 32-bit port with two locations: a data location that moves four bytes per access, and a location that takes a packed control word on write and returns a status word on read. On the line side it offers transmit bytes one at a time, each tagged with an end-of-frame mark, and it accepts receive bytes tagged with a frame end and a three-bit frame check pattern computed elsewhere.

Software sets the operating mode (framed or transparent, 32-byte or 128-byte FIFO, optional internal loopback), arms a transmit block with a byte count and an optional end-of-frame command, and fills the transmit FIFO with words. Received bytes are gathered into blocks that close on a frame end or when the FIFO fills; the block length, frame-end flag and check pattern are then reported in the status word. Service requests (transmit ready, transmit underrun, receive ready) are sticky, drive the interrupt output and clear when the status word is read.

Top module: `hdlc_chan_fifo`

## Requirements
- R1: A control write (select 1) takes the command byte from bits [7:0], the block length from bits [15:8] and the mode from bits [23:16]; mode bit 0 is framed, bit 1 transparent (wins over bit 0), bit 5 picks a 128-byte FIFO instead of 32, bit 7 loopback; a length of 0 arms a block as large as the selected FIFO.
- R2: A data write (select 0) loads its bytes lowest lane first, and only as many bytes as the armed block still lacks; lanes past the block length are discarded.
- R3: In framed mode, when command bit 0 was set with the block, tx_last is high on exactly the final byte of that block; in transparent mode tx_last stays low.
- R4: When the final byte of a fully loaded block leaves and the FIFO is empty, status bit 7 is set and irq goes high.
- R5: With tx_ready high and no byte available, a framed channel in the middle of a frame raises tx_abort for that cycle and ends the frame; a transparent channel shows the fill byte 8'hFF on tx_byte; both set status bit 6.
- R6: In framed mode a receive block closes on a byte with rx_end or when the FIFO fills; in transparent mode rx_end is ignored and only a full FIFO closes the block. A close sets status bit 5, bit 0 to the frame-end flag, bits [3:1] to the check pattern (good is 3'b011, zero when no frame end).
- R7: The receive length sits in status bits [14:8] for the 128-byte FIFO and [13:8] for the 32-byte FIFO, with 0 meaning a full FIFO.
- R8: A receive byte that arrives while the FIFO is full or a closed block is still unread is dropped and sets status bit 4.
- R9: A data read returns the next four received bytes lowest lane first, zero in lanes past the stored count, and consumes them; once a closed block is drained, a new frame is accepted.
- R10: Reading the status word clears bits 7, 6, 5 and 4; an event arriving in the same cycle as that read remains set.
- R11: Command bit 7 empties the transmit FIFO and its armed block, clears bit 6 and sets bit 7; command bit 5 empties the receive FIFO and clears bits 5, 4, 3:1, 0 and the length.
- R12: In loopback the transmitter drains one byte per cycle into the receiver with the check pattern 3'b011, tx_valid stays low and the external receive inputs are ignored.
- R13: After reset the status word reads as the version nibble (parameter, default 2) in bits [27:24] with all other bits zero, irq and tx_valid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (read side effects) |
| host_sel | input | 1 | 0 selects the data location, 1 the control/status location |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for the selected location |
| irq | output | 1 | Service request: any of status bits 7, 6, 5 |
| tx_valid | output | 1 | A transmit byte is presented |
| tx_ready | input | 1 | Line takes a byte this cycle |
| tx_byte | output | 8 | Transmit byte, or fill byte when empty |
| tx_last | output | 1 | Presented byte ends the frame |
| tx_abort | output | 1 | Framed underrun: abort the current frame |
| rx_valid | input | 1 | A receive byte is offered |
| rx_byte | input | 8 | Receive byte |
| rx_end | input | 1 | This byte ends the frame |
| rx_chk | input | 3 | Frame check pattern with the ending byte |

## Verification
The status read that clears the sticky bits and the events that set them can land on the same clock edge. The bench offers a frame-ending receive byte in the very cycle the host reads the status word; the word returned must still show the receive-ready bit clear, and the next read must show it set. The same pairing arises for a transmit reset against an underrun, where the reset is expected to win.

// File: rtl/hdlc_chan_pkg.sv
// Shared bit positions and mode type for the channel FIFO controller.
// Assumes the control word layout: command [7:0], length [15:8], mode [23:16].
package hdlc_chan_pkg;
    localparam int CMD_TX_RST  = 7;
    localparam int CMD_RX_RST  = 5;
    localparam int CMD_TX_END  = 0;
    localparam int MODE_BASE   = 16;
    localparam int MODE_FRAMED = 0;
    localparam int MODE_TRANSP = 1;
    localparam int MODE_WIDE   = 5;
    localparam int MODE_LOOP   = 7;
    localparam logic [2:0] CHK_GOOD = 3'b011;

    typedef struct packed {
        logic loop;
        logic wide;
        logic transp;
        logic framed;
    } chan_mode_t;
endpackage

// File: rtl/hdlc_chan_txq.sv
// Transmit FIFO and block sequencer. Host words are split into bytes
// (lowest lane first) up to the armed block length; bytes leave one per
// accepted cycle. Tracks the open frame for underrun handling.
// Assumes DEPTH_BIG and DEPTH_SMALL are powers of two, DEPTH_SMALL <= DEPTH_BIG.
module hdlc_chan_txq #(
    parameter int DEPTH_BIG   = 128,
    parameter int DEPTH_SMALL = 32,
    parameter logic [7:0] FILL_BYTE = 8'hFF,
    localparam int PW = $clog2(DEPTH_BIG),
    localparam int CW = PW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wide,
    input  logic          framed,
    input  logic          transp,
    input  logic          loop,
    input  logic          flush,
    input  logic          blk_arm,
    input  logic [CW-1:0] blk_len,
    input  logic          blk_xme,
    input  logic          wr_word,
    input  logic [31:0]   wdata,
    input  logic          tx_ready,
    output logic          tx_valid,
    output logic [7:0]    tx_byte,
    output logic          tx_last,
    output logic          tx_abort,
    output logic          take,
    output logic [7:0]    take_byte,
    output logic          take_last,
    output logic          xpr_evt,
    output logic          xdu_evt
);
    logic [8:0]    mem [DEPTH_BIG];
    logic [PW-1:0] rptr, wptr, mask;
    logic [CW-1:0] count, load_left, size, space, n_wr;
    logic          xme_q, in_frame, have, udr;
    logic [8:0]    head;

    // Active FIFO geometry
    assign mask  = wide ? PW'(DEPTH_BIG - 1) : PW'(DEPTH_SMALL - 1);
    assign size  = wide ? CW'(DEPTH_BIG) : CW'(DEPTH_SMALL);
    assign space = size - count;
    assign have  = (count != '0);
    assign head  = mem[rptr];

    // Bytes accepted from this host word: lane count, block rest, free space
    always_comb begin
        n_wr = CW'(4);
        if (load_left < n_wr) n_wr = load_left;
        if (space < n_wr)     n_wr = space;
        if (!wr_word)         n_wr = '0;
    end

    // Line side presentation and underrun detection
    assign take      = have & (loop | tx_ready);
    assign udr       = !loop & tx_ready & !have & (transp | (framed & in_frame));
    assign tx_valid  = have & !loop;
    assign tx_byte   = have ? head[7:0] : FILL_BYTE;
    assign tx_last   = tx_valid & head[8] & framed;
    assign tx_abort  = udr & framed;
    assign take_byte = head[7:0];
    assign take_last = head[8] & framed;
    assign xdu_evt   = udr;
    assign xpr_evt   = take & (count == CW'(1)) & (n_wr == '0) & (load_left == '0);

    // Byte storage: write the accepted lanes, flag the frame's final byte
    always_ff @(posedge clk) begin
        for (int i = 0; i < 4; i++) begin
            if (CW'(i) < n_wr)
                mem[(wptr + PW'(i)) & mask] <= {xme_q && (load_left == n_wr) && (CW'(i) == n_wr - CW'(1)),
                                                wdata[8*i +: 8]};
        end
    end

    // Pointers, occupancy, armed block and frame tracking
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rptr      <= '0;
            wptr      <= '0;
            count     <= '0;
            load_left <= '0;
            xme_q     <= 1'b0;
            in_frame  <= 1'b0;
        end else begin
            if (blk_arm) begin
                load_left <= blk_len;
                xme_q     <= blk_xme;
            end else begin
                load_left <= load_left - n_wr;
            end
            wptr  <= (wptr + PW'(n_wr)) & mask;
            rptr  <= take ? ((rptr + PW'(1)) & mask) : rptr;
            count <= count + n_wr - CW'(take);
            if (take && framed)     in_frame <= !head[8];
            else if (udr && framed) in_frame <= 1'b0;
        end
    end

    assert_tx_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        count <= size);
    assert_frame_opens_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_frame) |-> $past(take));
endmodule

// File: rtl/hdlc_chan_rxq.sv
// Receive FIFO and block closer. Bytes gather into a block that closes on
// a frame end (framed mode) or a full FIFO; the block is then held until
// the host drains it. Late bytes are dropped and flagged.
// Assumes power-of-two depths; length field is PW bits wide.
module hdlc_chan_rxq #(
    parameter int DEPTH_BIG   = 128,
    parameter int DEPTH_SMALL = 32,
    localparam int PW = $clog2(DEPTH_BIG),
    localparam int CW = PW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wide,
    input  logic          framed,
    input  logic          flush,
    input  logic          in_v,
    input  logic [7:0]    in_b,
    input  logic          in_end,
    input  logic [2:0]    in_chk,
    input  logic          rd_word,
    output logic [31:0]   rd_data,
    output logic          rpr_evt,
    output logic          ovr_evt,
    output logic [PW-1:0] rml,
    output logic          rme,
    output logic [2:0]    chk
);
    logic [7:0]    mem [DEPTH_BIG];
    logic [PW-1:0] rptr, wptr, mask;
    logic [CW-1:0] count, blk, blk_inc, size, n_rd;
    logic          hold, accept, close, ends;

    // Active geometry and acceptance
    assign mask    = wide ? PW'(DEPTH_BIG - 1) : PW'(DEPTH_SMALL - 1);
    assign size    = wide ? CW'(DEPTH_BIG) : CW'(DEPTH_SMALL);
    assign accept  = in_v & !hold & (count != size);
    assign ovr_evt = in_v & !accept;
    assign blk_inc = blk + CW'(1);
    assign ends    = framed & in_end;
    assign close   = accept & (ends | (blk_inc == size));
    assign rpr_evt = close;

    // Bytes consumed by a host word read
    always_comb begin
        n_rd = CW'(4);
        if (count < n_rd) n_rd = count;
        if (!rd_word)     n_rd = '0;
    end

    // Host word: stored bytes lowest lane first, zero past the count
    always_comb begin
        for (int i = 0; i < 4; i++)
            rd_data[8*i +: 8] = (CW'(i) < count) ? mem[(rptr + PW'(i)) & mask] : 8'h00;
    end

    // Byte storage
    always_ff @(posedge clk) begin
        if (accept) mem[wptr] <= in_b;
    end

    // Pointers, block tracking and block report
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rptr  <= '0;
            wptr  <= '0;
            count <= '0;
            blk   <= '0;
            hold  <= 1'b0;
            rml   <= '0;
            rme   <= 1'b0;
            chk   <= 3'b000;
        end else begin
            wptr  <= accept ? ((wptr + PW'(1)) & mask) : wptr;
            rptr  <= (rptr + PW'(n_rd)) & mask;
            count <= count + CW'(accept) - n_rd;
            blk   <= close ? '0 : blk + CW'(accept);
            if (close) begin
                hold <= 1'b1;
                rml  <= (blk_inc == size) ? '0 : blk_inc[PW-1:0];
                rme  <= ends;
                chk  <= ends ? in_chk : 3'b000;
            end else if (hold && (n_rd != '0) && (count == n_rd)) begin
                hold <= 1'b0;
            end
        end
    end

    assert_hold_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hold && !rd_word && !flush |=> count == $past(count));
    assert_rx_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        count <= size);
    assert_close_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rpr_evt && !flush |=> hold);
endmodule

// File: rtl/hdlc_chan_fifo.sv
// Channel FIFO controller top: host register decode, mode register,
// sticky service bits with clear-on-read, status word and loopback mux.
// Assumes DEPTH_BIG = 128 so the receive length fits status bits [14:8].
module hdlc_chan_fifo
    import hdlc_chan_pkg::*;
#(
    parameter int DEPTH_BIG   = 128,
    parameter int DEPTH_SMALL = 32,
    parameter logic [3:0] VERSION   = 4'h2,
    parameter logic [7:0] FILL_BYTE = 8'hFF,
    localparam int PW = $clog2(DEPTH_BIG),
    localparam int CW = PW + 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr,
    input  logic        host_rd,
    input  logic        host_sel,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    output logic        irq,
    output logic        tx_valid,
    input  logic        tx_ready,
    output logic [7:0]  tx_byte,
    output logic        tx_last,
    output logic        tx_abort,
    input  logic        rx_valid,
    input  logic [7:0]  rx_byte,
    input  logic        rx_end,
    input  logic [2:0]  rx_chk
);
    chan_mode_t    mode_q;
    logic          ctrl_wr, data_wr, stat_rd, data_rd, tx_rst, rx_rst, arm;
    logic          framed, xml_zero;
    logic [CW-1:0] blk_len;
    logic          xpr_q, xdu_q, rpr_q, rdo_q;
    logic          take, take_last, xpr_evt, xdu_evt, rpr_evt, ovr_evt;
    logic [7:0]    take_byte;
    logic          in_v, in_end;
    logic [7:0]    in_b;
    logic [2:0]    in_chk;
    logic [31:0]   rx_word, status;
    logic [PW-1:0] rml;
    logic          rme;
    logic [2:0]    chk;
    logic          ctrl_unused;

    // Host access decode
    assign ctrl_wr  = host_wr & host_sel;
    assign data_wr  = host_wr & !host_sel;
    assign stat_rd  = host_rd & host_sel;
    assign data_rd  = host_rd & !host_sel;
    assign tx_rst   = ctrl_wr & host_wdata[CMD_TX_RST];
    assign rx_rst   = ctrl_wr & host_wdata[CMD_RX_RST];
    assign arm      = ctrl_wr & !host_wdata[CMD_TX_RST];
    assign xml_zero = (host_wdata[15:8] == 8'h00);
    assign blk_len  = xml_zero ? (host_wdata[MODE_BASE + MODE_WIDE] ? CW'(DEPTH_BIG) : CW'(DEPTH_SMALL))
                               : CW'(host_wdata[15:8]);
    assign framed   = mode_q.framed & !mode_q.transp;
    assign ctrl_unused = ^{host_wdata[31:24], host_wdata[22], host_wdata[20:18],
                           host_wdata[6], host_wdata[4:1]};

    // Mode register, loaded by every control write
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= '0;
        else if (ctrl_wr)
            mode_q <= '{loop:   host_wdata[MODE_BASE + MODE_LOOP],
                        wide:   host_wdata[MODE_BASE + MODE_WIDE],
                        transp: host_wdata[MODE_BASE + MODE_TRANSP],
                        framed: host_wdata[MODE_BASE + MODE_FRAMED]};
    end

    // Sticky service bits: reset command first, then event, then read-clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xpr_q <= 1'b0;
            xdu_q <= 1'b0;
            rpr_q <= 1'b0;
            rdo_q <= 1'b0;
        end else begin
            if (tx_rst || xpr_evt) xpr_q <= 1'b1;
            else if (stat_rd)      xpr_q <= 1'b0;
            if (tx_rst)            xdu_q <= 1'b0;
            else if (xdu_evt)      xdu_q <= 1'b1;
            else if (stat_rd)      xdu_q <= 1'b0;
            if (rx_rst)            rpr_q <= 1'b0;
            else if (rpr_evt)      rpr_q <= 1'b1;
            else if (stat_rd)      rpr_q <= 1'b0;
            if (rx_rst)            rdo_q <= 1'b0;
            else if (ovr_evt)      rdo_q <= 1'b1;
            else if (stat_rd)      rdo_q <= 1'b0;
        end
    end

    // Receive source: loopback from the transmitter or the external input
    assign in_v   = mode_q.loop ? take      : rx_valid;
    assign in_b   = mode_q.loop ? take_byte : rx_byte;
    assign in_end = mode_q.loop ? take_last : rx_end;
    assign in_chk = mode_q.loop ? CHK_GOOD  : rx_chk;

    hdlc_chan_txq #(
        .DEPTH_BIG(DEPTH_BIG), .DEPTH_SMALL(DEPTH_SMALL), .FILL_BYTE(FILL_BYTE)
    ) u_txq (
        .clk(clk), .rst_n(rst_n), .wide(mode_q.wide), .framed(framed),
        .transp(mode_q.transp), .loop(mode_q.loop), .flush(tx_rst),
        .blk_arm(arm), .blk_len(blk_len), .blk_xme(host_wdata[CMD_TX_END]),
        .wr_word(data_wr), .wdata(host_wdata), .tx_ready(tx_ready),
        .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_last(tx_last),
        .tx_abort(tx_abort), .take(take), .take_byte(take_byte),
        .take_last(take_last), .xpr_evt(xpr_evt), .xdu_evt(xdu_evt)
    );

    hdlc_chan_rxq #(
        .DEPTH_BIG(DEPTH_BIG), .DEPTH_SMALL(DEPTH_SMALL)
    ) u_rxq (
        .clk(clk), .rst_n(rst_n), .wide(mode_q.wide), .framed(framed),
        .flush(rx_rst), .in_v(in_v), .in_b(in_b), .in_end(in_end),
        .in_chk(in_chk), .rd_word(data_rd), .rd_data(rx_word),
        .rpr_evt(rpr_evt), .ovr_evt(ovr_evt), .rml(rml), .rme(rme), .chk(chk)
    );

    // Status word assembly; the length field narrows with the small FIFO
    always_comb begin
        status         = '0;
        status[0]      = rme;
        status[3:1]    = chk;
        status[4]      = rdo_q;
        status[5]      = rpr_q;
        status[6]      = xdu_q;
        status[7]      = xpr_q;
        status[8 +: PW] = mode_q.wide ? rml : (rml & PW'(DEPTH_SMALL - 1));
        status[27:24]  = VERSION;
    end

    assign host_rdata = host_sel ? status : rx_word;
    assign irq        = xpr_q | xdu_q | rpr_q;

    assert_irq_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(stat_rd) || $past(ctrl_wr));
endmodule

// File: tb/hdlc_chan_fifo_tb.sv
`timescale 1ns/100ps
module hdlc_chan_fifo_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0, host_rd = 1'b0, host_sel = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        irq, tx_valid, tx_last, tx_abort;
    logic        tx_ready = 1'b0;
    logic [7:0]  tx_byte;
    logic        rx_valid = 1'b0, rx_end = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic [2:0]  rx_chk = '0;
    int          checks = 0, failures = 0;
    bit          done = 1'b0;
    logic [31:0] v;

    always #2 clk = ~clk;

    hdlc_chan_fifo u_dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .irq(irq), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_byte(tx_byte),
        .tx_last(tx_last), .tx_abort(tx_abort), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .rx_end(rx_end), .rx_chk(rx_chk)
    );

    // Receive frames: {bytes[7:0], end, chk[2:0], expected status[15:0]}
    localparam logic [27:0] RXV [4] = '{
        28'h05B0527, 28'h03E032D, 28'h2000020, 28'h0190123
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [31:0] d);
        host_sel = sel; host_wdata = d; host_wr = 1'b1;
        @(posedge clk); #1;
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [31:0] q);
        host_sel = sel; host_rd = 1'b1;
        #1 q = host_rdata;
        @(posedge clk); #1;
        host_rd = 1'b0;
    endtask

    task automatic push(input logic [7:0] b, input logic e, input logic [2:0] c);
        rx_byte = b; rx_end = e; rx_chk = c; rx_valid = 1'b1;
        @(posedge clk); #1;
        rx_valid = 1'b0; rx_end = 1'b0;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        #400000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        cycles(3);
        rst_n = 1'b1;
        cycles(1);

        // R13: reset state
        rd(1'b1, v);
        check("R13 status after reset", v, 32'h0200_0000);
        check("R13 irq/tx_valid after reset", {irq, tx_valid}, 0);

        // R6 R9: table of receive frames, framed mode, small FIFO
        for (int k = 0; k < 4; k++) begin
            int n;
            n = int'(RXV[k][27:20]);
            wr(1'b1, 32'h0001_0020);
            for (int i = 0; i < n; i++)
                push(8'(8'h40 * k + i), (i == n - 1) ? RXV[k][19] : 1'b0, RXV[k][18:16]);
            rd(1'b1, v);
            check("R6 R7 frame status", v & 32'hFFFF, {16'h0, RXV[k][15:0]});
            for (int w = 0; w < (n + 3) / 4; w++) begin
                logic [31:0] e;
                for (int j = 0; j < 4; j++)
                    e[8*j +: 8] = (4*w + j < n) ? 8'(8'h40 * k + 4*w + j) : 8'h00;
                rd(1'b0, v);
                check("R9 receive word", v, e);
            end
        end

        // R11 R4: transmit reset sets ready, read clears it
        wr(1'b1, 32'h0001_0080);
        check("R11 irq after transmit reset", {31'h0, irq}, 1);
        rd(1'b1, v);
        check("R11 ready bit after transmit reset", v & 32'hC0, 32'h80);
        check("R10 irq cleared by status read", {31'h0, irq}, 0);

        // R1 R2 R3 R4: framed 6-byte block with end mark
        wr(1'b1, 32'h0001_0601);
        wr(1'b0, 32'h4433_2211);
        wr(1'b0, 32'h8877_6655);
        tx_ready = 1'b1;
        for (int i = 0; i < 6; i++) begin
            check("R2 tx byte", {23'h0, tx_valid, tx_byte}, {23'h0, 1'b1, 8'(8'h11 * (i + 1))});
            check("R3 tx_last position", {31'h0, tx_last}, (i == 5) ? 1 : 0);
            @(posedge clk); #1;
        end
        tx_ready = 1'b0;
        check("R2 extra lanes dropped", {31'h0, tx_valid}, 0);
        check("R4 irq after block sent", {31'h0, irq}, 1);
        rd(1'b1, v);
        check("R4 ready bit", v & 32'hC0, 32'h80);

        // R5: framed underrun mid-frame aborts once
        wr(1'b1, 32'h0001_0200);
        wr(1'b0, 32'h0000_BBAA);
        tx_ready = 1'b1;
        cycles(2);
        check("R5 abort on framed underrun", {30'h0, tx_abort, tx_valid}, 32'h2);
        cycles(1);
        check("R5 abort lasts one cycle", {31'h0, tx_abort}, 0);
        tx_ready = 1'b0;
        rd(1'b1, v);
        check("R5 underrun and ready bits", v & 32'hC0, 32'hC0);

        // R5 R3: transparent mode, no end mark, fill byte on underrun
        wr(1'b1, 32'h0002_0080);
        rd(1'b1, v);
        wr(1'b1, 32'h0002_0401);
        wr(1'b0, 32'hDDCC_BBAA);
        tx_ready = 1'b1;
        for (int i = 0; i < 4; i++) begin
            check("R3 no tx_last in transparent", {31'h0, tx_last}, 0);
            @(posedge clk); #1;
        end
        check("R5 fill byte in transparent", {22'h0, tx_abort, tx_valid, tx_byte}, 32'h0FF);
        cycles(1);
        tx_ready = 1'b0;
        rd(1'b1, v);
        check("R5 transparent underrun bit", v & 32'h40, 32'h40);

        // R10: receive close in the same cycle as the status read
        wr(1'b1, 32'h0001_0020);
        rd(1'b1, v);
        rx_byte = 8'h5A; rx_end = 1'b1; rx_chk = 3'b011; rx_valid = 1'b1;
        host_sel = 1'b1; host_rd = 1'b1;
        #1 v = host_rdata;
        check("R10 read before simultaneous event", v & 32'h20, 32'h0);
        @(posedge clk); #1;
        host_rd = 1'b0; rx_valid = 1'b0; rx_end = 1'b0;
        rd(1'b1, v);
        check("R10 event kept over read-clear", v & 32'h20, 32'h20);
        rd(1'b0, v);
        check("R9 single byte word", v, 32'h0000_005A);

        // R8 R9: overrun while block held, then new frame after drain
        wr(1'b1, 32'h0001_0020);
        push(8'h21, 1'b0, 3'b011);
        push(8'h22, 1'b1, 3'b011);
        push(8'h77, 1'b0, 3'b011);
        rd(1'b1, v);
        check("R8 overrun status", v & 32'hFFFF, 32'h0237);
        rd(1'b0, v);
        check("R8 dropped byte absent", v, 32'h0000_2221);
        push(8'h31, 1'b1, 3'b011);
        rd(1'b1, v);
        check("R9 new frame after drain", v & 32'hFFFF, 32'h0127);
        rd(1'b0, v);

        // R7: large FIFO, 100-byte frame
        wr(1'b1, 32'h0021_0020);
        for (int i = 0; i < 100; i++) push(8'(i), (i == 99), 3'b011);
        rd(1'b1, v);
        check("R7 wide length field", v & 32'hFFFF, 32'h6427);
        for (int w = 0; w < 25; w++) begin
            rd(1'b0, v);
            if (w == 24) check("R9 last word of wide frame", v, 32'h6362_6160);
        end

        // R6: transparent receive ignores frame end, closes when full
        wr(1'b1, 32'h0002_0020);
        for (int i = 0; i < 3; i++) push(8'(i), (i == 2), 3'b011);
        rd(1'b1, v);
        check("R6 transparent ignores end", v & 32'hFFFF, 32'h0);
        for (int i = 3; i < 32; i++) push(8'(i), 1'b0, 3'b000);
        rd(1'b1, v);
        check("R6 R7 transparent full block", v & 32'hFFFF, 32'h0020);
        rd(1'b0, v);
        check("R9 transparent first word", v, 32'h0302_0100);
        for (int w = 1; w < 8; w++) rd(1'b0, v);

        // R12: loopback ignores external receive input
        wr(1'b1, 32'h0081_00A0);
        wr(1'b1, 32'h0081_0301);
        rx_valid = 1'b1; rx_byte = 8'hEE; rx_end = 1'b1; rx_chk = 3'b111;
        wr(1'b0, 32'h00C3_B2A1);
        for (int i = 0; i < 5; i++) begin
            check("R12 tx_valid low in loopback", {31'h0, tx_valid}, 0);
            @(posedge clk); #1;
        end
        rx_valid = 1'b0; rx_end = 1'b0;
        rd(1'b1, v);
        check("R12 loopback status", v & 32'hFFFF, 32'h03A7);
        rd(1'b0, v);
        check("R12 loopback data", v, 32'h00C3_B2A1);

        // R11: transmit reset flushes pending bytes
        wr(1'b1, 32'h0001_0401);
        wr(1'b0, 32'h1111_1111);
        check("R11 bytes pending", {31'h0, tx_valid}, 1);
        wr(1'b1, 32'h0001_0080);
        check("R11 transmit flushed", {31'h0, tx_valid}, 0);
        rd(1'b1, v);
        check("R11 ready set, underrun clear", v & 32'hC0, 32'h80);

        // R11: receive reset clears receive state
        push(8'h41, 1'b0, 3'b011);
        push(8'h42, 1'b1, 3'b011);
        wr(1'b1, 32'h0001_0020);
        rd(1'b1, v);
        check("R11 receive status cleared", v & 32'hFFFF, 32'h0);
        rd(1'b0, v);
        check("R11 receive FIFO empty", v, 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule